// File: doc/BRIEF.md
# Open-Drain Two-Line Pad Control Register

This block is a single memory-mapped control word that lets software drive a clock line and a data line as open-drain pads, so that a two-wire serial bus can be run entirely by software toggling bits. Each line has a stored direction bit and a stored output-value bit. Each of those bits has its own write-enable bit in the same word. One write can therefore move a line's direction without touching its value, or the other way round, and no read-modify-write is needed.

A line is pulled to ground only while its direction says "output" and its stored value is 0. Every other combination leaves the pad released, so an external pull-up can bring it high. Software raises a line by switching it back to input, with only the direction write-enable set. The sampled level of each pad is brought into the clock domain through a synchroniser and can be read in a read-only bit. Two more bits per word hold pull-up-disable settings for the two pads. These bits are plain storage with no write-enable, so software reads them back and rewrites them unchanged.

Pin 0 is the clock line and pin 1 is the data line. Each pin owns a group of `PIN_STRIDE` bits that starts at `pin*PIN_STRIDE`. Inside a group, bit 0 is direction (1 = output), bit 1 is the direction write-enable, bit 2 is the output value, bit 3 is the value write-enable and bit 4 is the synchronised input level. The pull-up-disable bit for pin i sits at `PU_BASE+i`.

Top module: `od_gpio_pair_reg`

## Requirements
- R1: After reset every stored bit reads 0, both pads are released (`pad_drive_low` = 0) and both pull-ups are enabled. Every input-level bit reads 0 until the synchroniser has filled.
- R2: A write changes a pin's direction bit (group bit 0) only when that pin's direction write-enable (group bit 1) is 1 in the same write. Otherwise the direction bit keeps its value.
- R3: A write changes a pin's output-value bit (group bit 2) only when that pin's value write-enable (group bit 3) is 1 in the same write. Otherwise the value bit keeps its value.
- R4: `pad_drive_low[i]` is 1 exactly when pin i's direction is output (1) and its stored value is 0.
- R5: Writing direction = input with only the direction write-enable set releases the pin and leaves its stored value unchanged.
- R6: Group bit 4 shows the level of `pad_in[i]`. A change on the pad appears there on the second rising edge after it, and not on the first.
- R7: On every write, the pull-up-disable bits at `PU_BASE+i` load `wr_data` directly. They read back exactly as written, and `pullup_en[i]` is their inverse.
- R8: Write-enable bits and all unassigned bits always read 0.
- R9: Fields of one pin are unaffected by writes addressed to the other pin's group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe; `wr_data` is applied at the rising edge |
| wr_data | input | DATA_W | Write word containing the fields and their write-enables |
| rd_data | output | DATA_W | Read word holding the stored fields and the synchronised input levels |
| pad_in | input | NUM_PINS | Raw pad levels (pin 0 clock, pin 1 data) |
| pad_drive_low | output | NUM_PINS | 1 pulls the pad to ground; 0 releases it |
| pullup_en | output | NUM_PINS | Pull-up enable for each pad, the inverse of the stored disable bit |

## Verification
The bench uses the default parameters: two pins, a 32-bit word, an 8-bit stride per pin, pull-up bits from bit 16 and a two-stage synchroniser. With these values the clock and data groups are far enough apart that a write aimed at one group cannot alias into the other. The two-stage depth makes the point where an input change becomes visible an exact cycle that the bench can check. A vector table steps through every combination of direction and value write-enables on both pins, while directed tests cover reset and the synchroniser latency.

// File: rtl/od_gpio_pkg.sv
package od_gpio_pkg;
   // Field offsets inside one pin's group of the control word.
   localparam int FLD_DIR      = 0;  // 1 = output
   localparam int FLD_DIR_WE   = 1;  // write-enable for FLD_DIR
   localparam int FLD_VAL      = 2;  // output level when driven
   localparam int FLD_VAL_WE   = 3;  // write-enable for FLD_VAL
   localparam int FLD_IN       = 4;  // synchronised pad level, read-only
   localparam int GROUP_FIELDS = 5;

   typedef struct packed {
      logic dir;
      logic val;
   } pin_state_t;
endpackage

// File: rtl/od_sync.sv
module od_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/od_pin_ctl.sv
module od_pin_ctl
   import od_gpio_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       dir_wr,
   input  logic       dir_we,
   input  logic       val_wr,
   input  logic       val_we,
   input  logic       pad_in,
   output pin_state_t state,
   output logic       in_level,
   output logic       drive_low
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= '0;
      end else if (wr_en) begin
         if (dir_we) state.dir <= dir_wr;
         if (val_we) state.val <= val_wr;
      end
   end

   // Open drain: only a driven 0 pulls the pad; a "1" is a release.
   assign drive_low = state.dir & ~state.val;

   od_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (in_level)
   );
endmodule

// File: rtl/od_pullup_reg.sv
module od_pullup_reg #(
   parameter int NUM = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [NUM-1:0] wr_bits,
   output logic [NUM-1:0] pu_dis
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pu_dis <= '0;
      else if (wr_en) pu_dis <= wr_bits;
   end
endmodule

// File: rtl/od_gpio_pair_reg.sv
module od_gpio_pair_reg
   import od_gpio_pkg::*;
#(
   parameter int NUM_PINS    = 2,
   parameter int DATA_W      = 32,
   parameter int PIN_STRIDE  = 8,
   parameter int PU_BASE     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [DATA_W-1:0]   rd_data,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_drive_low,
   output logic [NUM_PINS-1:0] pullup_en
);
   localparam int GROUP_END = NUM_PINS * PIN_STRIDE;
   localparam int PU_END    = PU_BASE + NUM_PINS;

   if (PIN_STRIDE < GROUP_FIELDS) begin : g_bad_stride
      $error("PIN_STRIDE too small for the pin fields");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PU_BASE < GROUP_END || PU_END > DATA_W) begin : g_bad_pu
      $error("pull-up field overlaps pin groups or exceeds DATA_W");
   end

   pin_state_t [NUM_PINS-1:0] st;
   logic       [NUM_PINS-1:0] in_lvl;
   logic       [NUM_PINS-1:0] pu_dis;
   logic       [NUM_PINS-1:0] pu_wr;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      od_pin_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_en),
         .dir_wr    (wr_data[i*PIN_STRIDE + FLD_DIR]),
         .dir_we    (wr_data[i*PIN_STRIDE + FLD_DIR_WE]),
         .val_wr    (wr_data[i*PIN_STRIDE + FLD_VAL]),
         .val_we    (wr_data[i*PIN_STRIDE + FLD_VAL_WE]),
         .pad_in    (pad_in[i]),
         .state     (st[i]),
         .in_level  (in_lvl[i]),
         .drive_low (pad_drive_low[i])
      );
      assign pu_wr[i] = wr_data[PU_BASE + i];
   end

   od_pullup_reg #(.NUM(NUM_PINS)) u_pu (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_bits (pu_wr),
      .pu_dis  (pu_dis)
   );

   assign pullup_en = ~pu_dis;

   // Read word: stored fields and input levels; write-enables read as 0.
   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         rd_data[i*PIN_STRIDE + FLD_DIR] = st[i].dir;
         rd_data[i*PIN_STRIDE + FLD_VAL] = st[i].val;
         rd_data[i*PIN_STRIDE + FLD_IN]  = in_lvl[i];
         rd_data[PU_BASE + i]            = pu_dis[i];
      end
   end

   // Bits of wr_data outside every field are deliberately ignored.
   logic unused_wr;
   assign unused_wr = ^wr_data;
endmodule

// File: rtl/od_gpio_pair_reg_chk.sv
module od_gpio_pair_reg_chk
   import od_gpio_pkg::*;
#(
   parameter int NUM_PINS   = 2,
   parameter int DATA_W     = 32,
   parameter int PIN_STRIDE = 8,
   parameter int PU_BASE    = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [DATA_W-1:0]   wr_data,
   input logic [DATA_W-1:0]   rd_data,
   input logic [NUM_PINS-1:0] pad_drive_low,
   input logic [NUM_PINS-1:0] pullup_en
);
   for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
      localparam int B = i * PIN_STRIDE;

      // R2
      dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !wr_data[B+FLD_DIR_WE]) |=> (rd_data[B+FLD_DIR] == $past(rd_data[B+FLD_DIR])));

      // R2
      dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_data[B+FLD_DIR_WE]) |=> (rd_data[B+FLD_DIR] == $past(wr_data[B+FLD_DIR])));

      // R3
      val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !wr_data[B+FLD_VAL_WE]) |=> (rd_data[B+FLD_VAL] == $past(rd_data[B+FLD_VAL])));

      // R3
      val_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_data[B+FLD_VAL_WE]) |=> (rd_data[B+FLD_VAL] == $past(wr_data[B+FLD_VAL])));

      // R4
      drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pad_drive_low[i] == (rd_data[B+FLD_DIR] && !rd_data[B+FLD_VAL]));

      // R8
      we_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_data[B+FLD_DIR_WE] && !rd_data[B+FLD_VAL_WE]);

      // R7
      pu_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en |=> (rd_data[PU_BASE+i] == $past(wr_data[PU_BASE+i])));

      // R7
      pu_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pullup_en[i] != rd_data[PU_BASE+i]);
   end
endmodule

bind od_gpio_pair_reg od_gpio_pair_reg_chk #(
   .NUM_PINS   (NUM_PINS),
   .DATA_W     (DATA_W),
   .PIN_STRIDE (PIN_STRIDE),
   .PU_BASE    (PU_BASE)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .wr_data       (wr_data),
   .rd_data       (rd_data),
   .pad_drive_low (pad_drive_low),
   .pullup_en     (pullup_en)
);

// File: tb/tb_od_gpio_pair_reg.sv
module tb_od_gpio_pair_reg;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 11;

   typedef struct packed {
      logic [31:0] wd;
      logic [31:0] rd;
      logic [1:0]  drv;
   } vec_t;

   // pad_in held at 2'b11 during the table, so bits 4 and 12 read 1.
   localparam vec_t VECS [NV] = '{
      '{32'h0000_000F, 32'h0000_1015, 2'b00},  // R2 R3 clk dir=out val=1: released
      '{32'h0000_000A, 32'h0000_1010, 2'b00},  // R4 clk dir=in val=0: released
      '{32'h0000_000B, 32'h0000_1011, 2'b01},  // R4 clk out low
      '{32'h0000_0B00, 32'h0000_1111, 2'b11},  // R9 data out low, clk kept
      '{32'h0000_0002, 32'h0000_1110, 2'b10},  // R5 clk release, val kept
      '{32'h0000_0001, 32'h0000_1110, 2'b10},  // R2 dir without write-enable ignored
      '{32'h0000_0004, 32'h0000_1110, 2'b10},  // R3 val without write-enable ignored
      '{32'h0000_000C, 32'h0000_1114, 2'b10},  // R3 clk val=1
      '{32'h0003_0000, 32'h0003_1114, 2'b10},  // R7 both pull-up disables set
      '{32'h0001_0600, 32'h0001_1014, 2'b00},  // R5 R7 data release, pu partial
      '{32'h0000_0000, 32'h0000_1014, 2'b00}   // R7 R8 pu cleared
   };

   logic        clk = 0;
   logic        rst_n = 0;
   logic        wr_en = 0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [1:0]  pad_in = 2'b00;
   logic [1:0]  pad_drive_low;
   logic [1:0]  pullup_en;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   od_gpio_pair_reg dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .wr_data       (wr_data),
      .rd_data       (rd_data),
      .pad_in        (pad_in),
      .pad_drive_low (pad_drive_low),
      .pullup_en     (pullup_en)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [31:0] d);
      @(negedge clk);
      wr_en = 1;
      wr_data = d;
      @(negedge clk);
      wr_en = 0;
      wr_data = '0;
   endtask

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 rd_data", rd_data, 32'h0);
      check("R1 drive", {30'b0, pad_drive_low}, 32'h0);
      check("R1 pullup", {30'b0, pullup_en}, 32'h3);
      rst_n = 1;

      // R6 synchroniser latency: change on pad, visible on second edge
      @(negedge clk);
      pad_in = 2'b01;
      @(negedge clk);
      check("R6 first edge", rd_data & 32'h0000_1010, 32'h0);
      @(negedge clk);
      check("R6 second edge", rd_data & 32'h0000_1010, 32'h0000_0010);
      pad_in = 2'b10;
      @(negedge clk);
      check("R6 data first edge", rd_data & 32'h0000_1010, 32'h0000_0010);
      @(negedge clk);
      check("R6 data second edge", rd_data & 32'h0000_1010, 32'h0000_1000);

      pad_in = 2'b11;
      repeat (3) @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         do_write(VECS[k].wd);
         check($sformatf("R2/R3/R7/R8 vec%0d rd", k), rd_data, VECS[k].rd);
         check($sformatf("R4 vec%0d drive", k), {30'b0, pad_drive_low}, {30'b0, VECS[k].drv});
         check($sformatf("R7 vec%0d pullup", k), {30'b0, pullup_en}, {30'b0, ~VECS[k].rd[17:16]});
      end

      // R8 write-enables and unassigned bits never read back
      do_write(32'hFFFF_FFFF);
      check("R8 all-ones write", rd_data, 32'h0003_1515);
      check("R4 all-ones drive", {30'b0, pad_drive_low}, 32'h0);

      // R1 reset again after activity
      @(negedge clk);
      pad_in = 2'b00;
      rst_n = 0;
      @(negedge clk);
      check("R1 re-reset rd_data", rd_data, 32'h0);
      check("R1 re-reset pullup", {30'b0, pullup_en}, 32'h3);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule